// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a clock synthesizer's dividers and its output drivers. It gates a CPU group, a memory group, one interrupt-controller clock and a PCI group so that each output can be stopped and restarted without a runt pulse. A free-running PCI reference clock and a free-running CPU clock pass straight through.

An output runs only when two things allow it: its bit in a per-output enable vector, and the stop pin that covers its group. The CPU-stop pin covers the CPU, memory and interrupt-controller lanes. The PCI-stop pin covers the PCI lanes. A mode strap can take the pins out of play.

Every change of state is handled the same way. The new allow value is captured on a rising edge of the free-running reference. The lane's own clock then applies it on its next falling edge. Because of this, a high phase is never cut short and a stopped output always rests low. After reset, all gated outputs stay low until a stabilisation counter in the reference domain expires.

Top module: `clkstop_ctrl`

## Requirements
- R1: A gated output that is stopped is held at logic 0, and a gated output is never high while its source clock is low.
- R2: A gated output never changes value while its source clock is high, so every high pulse it emits is a complete source high phase.
- R3: After a change on an enable bit, the lane keeps its old state through the next reference rising edge. The new state applies from the first falling edge of the lane's source clock after that reference edge.
- R4: With mode 0 and both stop pins at 0, every CPU, memory, interrupt-controller and PCI lane is stopped.
- R5: With mode 0, CPU-stop at 0 and PCI-stop at 1, the CPU, memory and interrupt-controller lanes stop and the PCI lanes follow their enable bits.
- R6: With mode 0, CPU-stop at 1 and PCI-stop at 0, only the PCI lanes stop; the other lanes follow their enable bits.
- R7: The free-running reference output and the free-running CPU output equal their source clocks at all times, whatever the pins, mode and enable bits are.
- R8: With mode at 1, both stop pins are treated as 1 (deasserted), so every lane follows its enable bit.
- R9: A lane runs only if its enable bit is 1 AND its group's stop pin allows it. Bit order of the enable vector, from bit 0 upward: CPU lanes, memory lanes, the interrupt-controller lane, then PCI lanes.
- R10: During reset, and for STAB_CYCLES reference rising edges after reset is released, every gated output is 0.
- R11: A stop-pin change passes through two reference-domain synchronizer flops. A lane therefore keeps its old state through three reference rising edges after the pin changes, and switches at the following falling edge of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Free-running PCI reference clock; sequences all changes |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | Source clock of the CPU lanes, also the free-running CPU output |
| mem_clk_i | input | 1 | Source clock of the memory lanes |
| apic_clk_i | input | 1 | Source clock of the interrupt-controller lane |
| pci_clk_i | input | 1 | Source clock of the PCI lanes |
| mode_i | input | 1 | 1 disables both stop pins |
| cpu_stop_n_i | input | 1 | Active-low stop for CPU, memory and interrupt-controller lanes |
| pci_stop_n_i | input | 1 | Active-low stop for PCI lanes |
| lane_en_i | input | N_LANES | Per-lane enable bits from the control register |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| mem_clk_o | output | N_MEM | Gated memory clocks |
| apic_clk_o | output | 1 | Gated interrupt-controller clock |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| cpu_free_o | output | 1 | Free-running CPU clock |
| ref_clk_o | output | 1 | Free-running PCI reference clock |

## Verification
The hardest case to create is a stop request that lands in the middle of a lane's high phase, where that phase spans a reference rising edge.

The bench achieves this by running the PCI source at the reference rate with a fixed quarter-period offset. It then flips one enable bit, or one stop pin, one nanosecond after a known reference edge. It samples the lane just before that edge, across it, and one and two source periods later.

These samples pin down the exact edge on which the lane switches, and they show that the straddling pulse is completed. A continuous sampler runs alongside and flags any output change during a source high phase.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/100ps
package clkstop_pkg;

  typedef enum logic [1:0] {
    GRP_CPU  = 2'd0,
    GRP_MEM  = 2'd1,
    GRP_APIC = 2'd2,
    GRP_PCI  = 2'd3
  } grp_e;

  // Lane numbering: CPU lanes, memory lanes, the interrupt-controller lane, PCI lanes.
  function automatic grp_e lane_group(int idx, int ncpu, int nmem);
    if (idx < ncpu)             return GRP_CPU;
    if (idx < ncpu + nmem)      return GRP_MEM;
    if (idx == ncpu + nmem)     return GRP_APIC;
    return GRP_PCI;
  endfunction

  // Which stop pin governs a group: only the PCI group follows the PCI pin.
  function automatic logic grp_runs(grp_e g, logic cpu_run, logic pci_run);
    return (g == GRP_PCI) ? pci_run : cpu_run;
  endfunction

  // A pin counts as "run" when it is high or when the mode strap disables it.
  function automatic logic pin_run(logic mode, logic pin_n);
    return mode | pin_n;
  endfunction

endpackage

// File: rtl/clkstop_pin_sync.sv
`timescale 1ns/100ps
module clkstop_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic pin_n,
  output logic run
);
  import clkstop_pkg::*;

  logic [STAGES-1:0] chain;

  // Reset to "run": gating is held off by the stabilisation timer anyway.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], pin_run(mode, pin_n)};
  end

  assign run = chain[STAGES-1];
endmodule

// File: rtl/clkstop_stab_timer.sv
`timescale 1ns/100ps
module clkstop_stab_timer #(
  parameter int CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end
endmodule

// File: rtl/clkstop_lane.sv
`timescale 1ns/100ps
module clkstop_lane (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic src_clk,
  input  logic allow,
  output logic req,
  output logic clk_out
);
  logic gate;

  // Step one: capture the request on the reference rising edge.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= allow;
  end

  // Step two: apply it on the source falling edge, while the source is low.
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= req;
  end

  assign clk_out = src_clk & gate;
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/100ps
module clkstop_ctrl #(
  parameter int N_CPU       = 2,
  parameter int N_MEM       = 13,
  parameter int N_PCI       = 5,
  parameter int STAB_CYCLES = 100000,
  parameter int SYNC_STAGES = 2,
  localparam int N_LANES    = N_CPU + N_MEM + 1 + N_PCI
) (
  input  logic               ref_clk_i,
  input  logic               rst_n_i,
  input  logic               cpu_clk_i,
  input  logic               mem_clk_i,
  input  logic               apic_clk_i,
  input  logic               pci_clk_i,
  input  logic               mode_i,
  input  logic               cpu_stop_n_i,
  input  logic               pci_stop_n_i,
  input  logic [N_LANES-1:0] lane_en_i,
  output logic [N_CPU-1:0]   cpu_clk_o,
  output logic [N_MEM-1:0]   mem_clk_o,
  output logic               apic_clk_o,
  output logic [N_PCI-1:0]   pci_clk_o,
  output logic               cpu_free_o,
  output logic               ref_clk_o
);
  import clkstop_pkg::*;

  localparam int APIC_IDX = N_CPU + N_MEM;
  localparam int PCI_BASE = APIC_IDX + 1;

  logic               cpu_run_s;
  logic               pci_run_s;
  logic               stab_done;
  logic [N_LANES-1:0] lane_allow;
  logic [N_LANES-1:0] lane_req;
  logic [N_LANES-1:0] lane_out;

  clkstop_pin_sync #(.STAGES(SYNC_STAGES)) u_cpu_sync (
    .clk(ref_clk_i), .rst_n(rst_n_i), .mode(mode_i),
    .pin_n(cpu_stop_n_i), .run(cpu_run_s)
  );

  clkstop_pin_sync #(.STAGES(SYNC_STAGES)) u_pci_sync (
    .clk(ref_clk_i), .rst_n(rst_n_i), .mode(mode_i),
    .pin_n(pci_stop_n_i), .run(pci_run_s)
  );

  clkstop_stab_timer #(.CYCLES(STAB_CYCLES)) u_stab (
    .clk(ref_clk_i), .rst_n(rst_n_i), .done(stab_done)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    localparam grp_e GRP = lane_group(i, N_CPU, N_MEM);
    logic src;

    if (GRP == GRP_CPU) begin : g_src
      assign src = cpu_clk_i;
    end else if (GRP == GRP_MEM) begin : g_src
      assign src = mem_clk_i;
    end else if (GRP == GRP_APIC) begin : g_src
      assign src = apic_clk_i;
    end else begin : g_src
      assign src = pci_clk_i;
    end

    assign lane_allow[i] = lane_en_i[i] & grp_runs(GRP, cpu_run_s, pci_run_s) & stab_done;

    clkstop_lane u_lane (
      .ref_clk(ref_clk_i), .rst_n(rst_n_i), .src_clk(src),
      .allow(lane_allow[i]), .req(lane_req[i]), .clk_out(lane_out[i])
    );
  end

  assign cpu_clk_o  = lane_out[N_CPU-1:0];
  assign mem_clk_o  = lane_out[N_CPU +: N_MEM];
  assign apic_clk_o = lane_out[APIC_IDX];
  assign pci_clk_o  = lane_out[PCI_BASE +: N_PCI];
  assign cpu_free_o = cpu_clk_i;
  assign ref_clk_o  = ref_clk_i;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/100ps
module clkstop_ctrl_chk #(
  parameter int N_CPU   = 2,
  parameter int N_MEM   = 13,
  parameter int N_LANES = 21
) (
  input logic               ref_clk,
  input logic               rst_n,
  input logic               mode,
  input logic               cpu_run_s,
  input logic               pci_run_s,
  input logic               stab_done,
  input logic [N_LANES-1:0] lane_en,
  input logic [N_LANES-1:0] lane_req
);
  localparam logic [N_LANES-1:0] PCI_MASK = {N_LANES{1'b1}} << (N_CPU + N_MEM + 1);
  localparam logic [N_LANES-1:0] CPU_MASK = ~PCI_MASK;

  p_hold_until_stable_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !stab_done |=> lane_req == '0);

  p_reg_and_pin_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (lane_req & ~$past(lane_en)) == '0);

  p_both_stopped_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!cpu_run_s && !pci_run_s) |=> lane_req == '0);

  p_cpu_group_stop_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !cpu_run_s |=> (lane_req & CPU_MASK) == '0);

  p_pci_group_stop_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !pci_run_s |=> (lane_req & PCI_MASK) == '0);

  p_mode_masks_pins_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mode && $past(mode) && $past(mode, 2)) |-> (cpu_run_s && pci_run_s));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
  .N_CPU(N_CPU), .N_MEM(N_MEM), .N_LANES(N_LANES)
) u_chk (
  .ref_clk(ref_clk_i), .rst_n(rst_n_i), .mode(mode_i),
  .cpu_run_s(cpu_run_s), .pci_run_s(pci_run_s), .stab_done(stab_done),
  .lane_en(lane_en_i), .lane_req(lane_req)
);

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/100ps
module clkstop_ctrl_bench;
  localparam int NC = 2, NM = 3, NP = 3, STAB = 16;
  localparam int NL = NC + NM + 1 + NP;   // 9 lanes: [1:0] cpu, [4:2] mem, [5] apic, [8:6] pci
  localparam int PCI0 = 6;

  logic clk = 1'b0, cpu_clk = 1'b0, mem_clk = 1'b0, apic_clk = 1'b0, pci_clk = 1'b0;
  logic rst_n = 1'b0, mode = 1'b0, cpu_n = 1'b1, pci_n = 1'b1;
  logic [NL-1:0] en = '1;
  logic [NC-1:0] cpu_o;
  logic [NM-1:0] mem_o;
  logic          apic_o;
  logic [NP-1:0] pci_o;
  logic          cpu_free, ref_out;

  int n_checks = 0, n_fail = 0;
  int r1_bad = 0, r2_bad = 0, r7_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;                                            // rises at 10 mod 20
  initial begin #2; forever #5 cpu_clk = ~cpu_clk; end
  initial begin #3; forever #4 mem_clk = ~mem_clk; end
  initial begin #1; forever #8 apic_clk = ~apic_clk; end
  initial begin #5; forever begin pci_clk = 1'b1; #10; pci_clk = 1'b0; #10; end end  // high 5..15 mod 20

  clkstop_ctrl #(.N_CPU(NC), .N_MEM(NM), .N_PCI(NP), .STAB_CYCLES(STAB)) u_clkstop_ctrl (
    .ref_clk_i(clk), .rst_n_i(rst_n), .cpu_clk_i(cpu_clk), .mem_clk_i(mem_clk),
    .apic_clk_i(apic_clk), .pci_clk_i(pci_clk), .mode_i(mode), .cpu_stop_n_i(cpu_n),
    .pci_stop_n_i(pci_n), .lane_en_i(en), .cpu_clk_o(cpu_o), .mem_clk_o(mem_o),
    .apic_clk_o(apic_o), .pci_clk_o(pci_o), .cpu_free_o(cpu_free), .ref_clk_o(ref_out)
  );

  wire [NL-1:0] outs = {pci_o, apic_o, mem_o, cpu_o};
  wire [NL-1:0] srcs = {{NP{pci_clk}}, apic_clk, {NM{mem_clk}}, {NC{cpu_clk}}};

  // Continuous sampler at half-nanosecond offsets, away from every edge.
  initial begin
    logic [NL-1:0] po, ps;
    #0.5;
    po = outs; ps = srcs;
    forever begin
      #1;
      if ((outs & ~srcs) != '0) r1_bad++;                 // R1
      if (((ps & srcs) & (po ^ outs)) != '0) r2_bad++;    // R2
      if (ref_out !== clk || cpu_free !== cpu_clk) r7_bad++; // R7
      po = outs; ps = srcs;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // {mode, cpu_stop_n, pci_stop_n, enable[8:0], expected running lanes[8:0]}
  localparam logic [20:0] VEC [0:8] = '{
    {1'b0, 1'b1, 1'b1, 9'h1FF, 9'h1FF},
    {1'b0, 1'b0, 1'b1, 9'h1FF, 9'h1C0},
    {1'b0, 1'b1, 1'b0, 9'h1FF, 9'h03F},
    {1'b0, 1'b0, 1'b0, 9'h1FF, 9'h000},
    {1'b1, 1'b0, 1'b0, 9'h1FF, 9'h1FF},
    {1'b0, 1'b1, 1'b1, 9'h0AA, 9'h0AA},
    {1'b0, 1'b0, 1'b1, 9'h155, 9'h140},
    {1'b0, 1'b1, 1'b0, 9'h0F3, 9'h033},
    {1'b1, 1'b1, 1'b0, 9'h12C, 9'h12C}
  };

  function automatic string row_tag(int r);
    case (r)
      1, 6:    return "R5";
      2, 7:    return "R6";
      3:       return "R4";
      4, 8:    return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NL-1:0] run_ok, park_ok, exp;
    bit hi;

    // R10: reset state.
    #25;
    check(outs == '0, "R10 reset", outs, 0);

    // R10: release reset one ns after a reference edge, watch STAB reference periods.
    @(posedge clk); #1 rst_n = 1'b1;
    #0.5;
    hi = 1'b0;
    for (int k = 0; k < STAB * 20; k++) begin
      if (outs != '0) hi = 1'b1;
      #1;
    end
    check(!hi, "R10 stabilisation hold", hi, 0);

    // Table walk.
    for (int r = 0; r < 9; r++) begin
      {mode, cpu_n, pci_n, en, exp} = VEC[r];
      repeat (8) @(posedge clk);
      #0.5;
      run_ok = '1; park_ok = '1;
      for (int k = 0; k < 80; k++) begin
        run_ok  &= ~(outs ^ srcs);
        park_ok &= ~outs;
        #1;
      end
      check(run_ok == exp && park_ok == ~exp, row_tag(r), run_ok, exp);
    end

    // R3: enable bit of PCI lane 0 cleared 1 ns after reference edge T.
    {mode, cpu_n, pci_n, en} = {1'b0, 1'b1, 1'b1, 9'h1FF};
    repeat (8) @(posedge clk);
    @(posedge clk); #1 en[PCI0] = 1'b0;
    #16.5 check(outs[PCI0] == 1'b1, "R3 before capture", outs[PCI0], 1);
    #5    check(outs[PCI0] == 1'b1, "R3 pulse spanning edge completes", outs[PCI0], 1);
    #15   check(outs[PCI0] == 1'b0, "R3 stopped after falling edge", outs[PCI0], 0);
    repeat (4) @(posedge clk);
    @(posedge clk); #1 en[PCI0] = 1'b1;
    #16.5 check(outs[PCI0] == 1'b0, "R3 still stopped before capture", outs[PCI0], 0);
    #20   check(outs[PCI0] == 1'b1, "R3 restarted", outs[PCI0], 1);

    // R11: PCI-stop pin latency through the synchronizer.
    repeat (4) @(posedge clk);
    @(posedge clk); #1 pci_n = 1'b0;
    #56.5 check(outs[PCI0] == 1'b1, "R11 old state through three ref edges", outs[PCI0], 1);
    #20   check(outs[PCI0] == 1'b0, "R11 stopped after sync", outs[PCI0], 0);
    pci_n = 1'b1;
    repeat (8) @(posedge clk);

    check(r1_bad == 0, "R1 never high while source low", r1_bad, 0);
    check(r2_bad == 0, "R2 no change during high phase", r2_bad, 0);
    check(r7_bad == 0, "R7 free-running outputs", r7_bad, 0);
    finish_run();
  end
endmodule